// File: doc/BRIEF.md
# I2C Master Bus-Sequence Engine

This block is the sequencing core of an I2C master. Software writes a control byte. Five one-shot bits select a bus sequence: Start, repeated Start, Stop, acknowledge, or receive one byte. The engine drives the open-drain SDA and SCL lines through that sequence, one quarter of a bit time per step, and clears the bit itself when the sequence is complete. A write to the transmit byte port starts a byte transmit. The engine shifts out eight bits and then frees SDA for a ninth clock, and the slave's answer on that clock is kept as the acknowledge status.

Bit timing comes from a reload divider: each quarter phase lasts `div_reload + 1` clock cycles. A one-cycle `done_irq` pulse marks the end of every sequence. Only one sequence runs at a time. While the engine is busy, command bits and byte writes are dropped and never queued.

Both bus lines are open-drain. `sda_oe` and `scl_oe` pull their line low when high, and `sda_i` returns the wired bus level.

Top module: `i2c_seq_master`

## Requirements
- R1: After reset, `reg_rdata` is 0x00, both lines are released and `done_irq` is low.
- R2: Control bit 0 runs a Start. SDA falls while SCL is high, and SCL is pulled low two quarters later. Both lines stay held low afterwards, and bit 0 reads 1 while the Start runs and 0 once it is done.
- R3: Control bit 1 runs a repeated Start. SDA is released, then SCL, then SDA falls while SCL is high, and finally SCL is pulled low. Both lines stay held low afterwards.
- R4: Control bit 2 runs a Stop. SDA is pulled low while SCL is low, SCL is released, then SDA rises while SCL is high. Both lines end released.
- R5: Control bit 3 clocks in eight bits, MSB first, each sampled while SCL is high. The byte appears on `rx_data` at completion.
- R6: A write to `buf_we` in idle transmits the byte MSB first on eight SCL pulses. SDA is then released for a ninth pulse, and the SDA level on that pulse is stored in control bit 6 (1 means no acknowledge, 0 means acknowledge).
- R7: Control bit 6 is read-only, and a register write does not change it.
- R8: Control bit 4 runs an acknowledge clock that drives the value of control bit 5 on SDA (0 drives ACK, 1 drives NACK). During transmit, receive and acknowledge, SDA changes only while SCL is low.
- R9: When the engine is not idle, a register write leaves bits 4..0 unchanged and starts nothing, and a write to `buf_we` starts no transmit.
- R10: `done_irq` is high for exactly one cycle. It rises after the edge at which the command was accepted plus Q×n cycles, where Q = `div_reload` + 1 and n is 4 for Start, Stop and acknowledge, 6 for repeated Start, 36 for transmit and 32 for receive.
- R11: If an idle write sets several of bits 4..0, only the lowest set bit is taken. Bits 7 (general-call enable) and 5 store the written value on every write.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| reg_we | input | 1 | Control register write strobe |
| reg_wdata | input | 8 | Control register write data |
| reg_rdata | output | 8 | Control register contents |
| buf_we | input | 1 | Transmit byte write strobe |
| buf_wdata | input | 8 | Byte to transmit |
| rx_data | output | 8 | Last received byte |
| div_reload | input | DIV_W | Quarter-phase divider reload value |
| sda_i | input | 1 | Sampled SDA bus level |
| sda_oe | output | 1 | 1 pulls SDA low |
| scl_oe | output | 1 | 1 pulls SCL low |
| done_irq | output | 1 | One-cycle pulse at the end of a sequence |

## Verification
Every result is due a fixed number of cycles after the accepting edge. That number is Q×n, with n set by the sequence type (4, 6, 32 or 36). The bench counts falling clock edges from the accepting edge until `done_irq` is seen and compares the count with that product exactly, using two divider settings. Line levels, the received byte and the status bits are read on the falling edge where the pulse first shows. Bus events such as SDA falling or rising with SCL high, and the bit seen on each SCL rise, are recorded by monitors on the line edges. They are compared after the pulse.

// File: rtl/i2c_seq_master.sv
module i2c_seq_master #(
  parameter int DIV_W = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             reg_we,
  input  logic [7:0]       reg_wdata,
  output logic [7:0]       reg_rdata,
  input  logic             buf_we,
  input  logic [7:0]       buf_wdata,
  output logic [7:0]       rx_data,
  input  logic [DIV_W-1:0] div_reload,
  input  logic             sda_i,
  output logic             sda_oe,
  output logic             scl_oe,
  output logic             done_irq
);
  localparam int STEP_W = 6;

  typedef enum logic [2:0] {S_IDLE, S_START, S_RSTART, S_STOP, S_TX, S_RX, S_ACK} state_t;

  state_t            st;
  logic [DIV_W-1:0]  cnt;
  logic [STEP_W-1:0] step;
  logic [7:0]        sh, rxd;
  logic [4:0]        cmd, newc;
  logic              gcen, ackstat, ackdt, sda_low, scl_low, done;
  logic              tick, last, take_cmd, take_buf;
  logic [1:0]        ph;
  logic [3:0]        bitk;

  assign ph        = step[1:0];
  assign bitk      = step[5:2];
  assign tick      = (st != S_IDLE) && (cnt == '0);
  assign take_cmd  = reg_we && (st == S_IDLE) && (|reg_wdata[4:0]);
  assign take_buf  = buf_we && (st == S_IDLE) && !take_cmd;
  assign reg_rdata = {gcen, ackstat, ackdt, cmd};
  assign rx_data   = rxd;
  assign sda_oe    = sda_low;
  assign scl_oe    = scl_low;
  assign done_irq  = done;

  always_comb begin
    newc = '0;
    if      (reg_wdata[0]) newc[0] = 1'b1;
    else if (reg_wdata[1]) newc[1] = 1'b1;
    else if (reg_wdata[2]) newc[2] = 1'b1;
    else if (reg_wdata[3]) newc[3] = 1'b1;
    else if (reg_wdata[4]) newc[4] = 1'b1;
  end

  always_comb begin
    case (st)
      S_START, S_STOP, S_ACK: last = tick && (step == 6'd3);
      S_RSTART:               last = tick && (step == 6'd5);
      S_TX:                   last = tick && (step == 6'd35);
      S_RX:                   last = tick && (step == 6'd31);
      default:                last = 1'b0;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st <= S_IDLE; cnt <= '0; step <= '0; sh <= '0; rxd <= '0; cmd <= '0;
      gcen <= 1'b0; ackstat <= 1'b0; ackdt <= 1'b0;
      sda_low <= 1'b0; scl_low <= 1'b0; done <= 1'b0;
    end else begin
      done <= 1'b0;
      if (reg_we) begin
        gcen  <= reg_wdata[7];
        ackdt <= reg_wdata[5];
      end
      if (st == S_IDLE) begin
        cnt  <= div_reload;
        step <= '0;
        if (take_cmd) begin
          cmd <= newc;
          if      (newc[0]) st <= S_START;
          else if (newc[1]) st <= S_RSTART;
          else if (newc[2]) st <= S_STOP;
          else if (newc[3]) st <= S_RX;
          else              st <= S_ACK;
        end else if (take_buf) begin
          sh <= buf_wdata;
          st <= S_TX;
        end
      end else if (!tick) begin
        cnt <= cnt - 1'b1;
      end else begin
        cnt  <= div_reload;
        step <= step + 1'b1;
        case (st)
          S_START: begin
            if (ph == 2'd0) sda_low <= 1'b1;
            if (ph == 2'd2) scl_low <= 1'b1;
          end
          S_STOP: begin
            if (ph == 2'd0) sda_low <= 1'b1;
            if (ph == 2'd1) scl_low <= 1'b0;
            if (ph == 2'd2) sda_low <= 1'b0;
          end
          S_RSTART: begin
            if (step == 6'd0) sda_low <= 1'b0;
            if (step == 6'd1) scl_low <= 1'b0;
            if (step == 6'd3) sda_low <= 1'b1;
            if (step == 6'd5) scl_low <= 1'b1;
          end
          S_TX: begin
            if (ph == 2'd0) sda_low <= (bitk == 4'd8) ? 1'b0 : ~sh[7];
            if (ph == 2'd1) scl_low <= 1'b0;
            if (ph == 2'd2 && bitk == 4'd8) ackstat <= sda_i;
            if (ph == 2'd3) begin
              scl_low <= 1'b1;
              sh <= {sh[6:0], 1'b0};
            end
          end
          S_RX: begin
            if (ph == 2'd0) sda_low <= 1'b0;
            if (ph == 2'd1) scl_low <= 1'b0;
            if (ph == 2'd2) sh <= {sh[6:0], sda_i};
            if (ph == 2'd3) scl_low <= 1'b1;
            if (last) rxd <= sh;
          end
          S_ACK: begin
            if (ph == 2'd0) sda_low <= ~ackdt;
            if (ph == 2'd1) scl_low <= 1'b0;
            if (ph == 2'd3) scl_low <= 1'b1;
          end
          default: ;
        endcase
        if (last) begin
          st   <= S_IDLE;
          cmd  <= '0;
          done <= 1'b1;
        end
      end
    end
  end

  p_cmd_onehot_r11: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(cmd));

  p_done_pulse_r10: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done);

  p_clear_on_done_r2: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> (cmd == '0));

  p_no_spool_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (st != S_IDLE && reg_we && !tick) |=> $stable(cmd));

  p_sda_steady_r8: assert property (@(posedge clk) disable iff (!rst_n)
    ((st == S_TX || st == S_RX || st == S_ACK) && $past(st) == st &&
     !scl_low && !$past(scl_low)) |-> $stable(sda_low));

  p_stop_release_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (done && $past(st) == S_STOP) |-> (!sda_low && !scl_low));
endmodule

// File: tb/i2c_seq_master_bench.sv
module i2c_seq_master_bench;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       reg_we = 1'b0, buf_we = 1'b0;
  logic [7:0] reg_wdata = '0, buf_wdata = '0;
  logic [7:0] reg_rdata, rx_data;
  logic [7:0] div_reload = 8'd3;
  logic       sda_oe, scl_oe, done_irq;
  logic       spull = 1'b0;
  logic       sda_bus, scl_line;

  int errs = 0, checks = 0, cyc = 0;
  int falls = 0, smode = 0, start_seen = 0, stop_seen = 0;
  logic       ack_drive = 1'b0;
  logic [7:0] rx_pat = '0;
  logic [8:0] cap = '0;

  always #4 clk = ~clk;

  assign sda_bus  = ~sda_oe & ~spull;
  assign scl_line = ~scl_oe;

  i2c_seq_master #(.DIV_W(8)) u_i2c_seq_master (
    .clk(clk), .rst_n(rst_n), .reg_we(reg_we), .reg_wdata(reg_wdata),
    .reg_rdata(reg_rdata), .buf_we(buf_we), .buf_wdata(buf_wdata),
    .rx_data(rx_data), .div_reload(div_reload), .sda_i(sda_bus),
    .sda_oe(sda_oe), .scl_oe(scl_oe), .done_irq(done_irq));

  always @(posedge scl_line) cap = {cap[7:0], sda_bus};
  always @(negedge sda_bus) if (scl_line) start_seen++;
  always @(posedge sda_bus) if (scl_line) stop_seen++;
  always @(negedge scl_line) begin
    falls++;
    if (smode == 1) begin
      if (falls == 8) spull = ack_drive;
      else if (falls == 9) spull = 1'b0;
    end else if (smode == 2) begin
      if (falls < 8) spull = ~rx_pat[7-falls];
      else spull = 1'b0;
    end
  end

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    checks++;
    if (!ok) begin
      errs++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic summary();
    $display("Result: errors=%0d of %0d checks", errs, checks);
    $finish;
  endtask

  always @(posedge clk) begin
    cyc++;
    if (cyc > 150000) begin
      errs++; checks++;
      $display("FAIL watchdog actual=%0d expected=<150000", cyc);
      summary();
    end
  end

  task automatic wr_reg(input logic [7:0] d);
    @(negedge clk); reg_we = 1'b1; reg_wdata = d;
    @(negedge clk); reg_we = 1'b0;
  endtask

  task automatic wr_buf(input logic [7:0] d);
    @(negedge clk); buf_we = 1'b1; buf_wdata = d;
    @(negedge clk); buf_we = 1'b0;
  endtask

  task automatic wait_done(output int k);
    k = 0;
    while (!done_irq && k < 3000) begin @(negedge clk); k++; end
  endtask

  task automatic t_reset();
    chk(reg_rdata == 8'h00, "R1 rdata", reg_rdata, 0);
    chk(!sda_oe && !scl_oe && !done_irq, "R1 lines", {sda_oe, scl_oe, done_irq}, 0);
  endtask

  task automatic t_start();
    int k, s0;
    s0 = start_seen;
    wr_reg(8'h01);
    chk(reg_rdata[4:0] == 5'h01, "R2 bit set", reg_rdata[4:0], 1);
    wait_done(k);
    chk(k == 16, "R10 start timing", k, 16);
    chk(sda_oe && scl_oe, "R2 lines held", {sda_oe, scl_oe}, 3);
    chk(reg_rdata[4:0] == 0, "R2 bit cleared", reg_rdata[4:0], 0);
    chk(start_seen == s0 + 1, "R2 start event", start_seen, s0 + 1);
    @(negedge clk);
    chk(!done_irq, "R10 one-cycle pulse", done_irq, 0);
  endtask

  task automatic t_tx(input logic [7:0] d, input logic nack);
    int k;
    falls = 0; cap = '0; smode = 1; ack_drive = ~nack;
    wr_buf(d);
    wait_done(k);
    chk(k == 144, "R10 tx timing", k, 144);
    chk(cap[8:1] == d, "R6 tx bits", cap[8:1], d);
    chk(reg_rdata[6] == nack, "R6 ack status", reg_rdata[6], nack);
    chk(falls == 9, "R6 nine clocks", falls, 9);
    smode = 0;
  endtask

  task automatic t_rx(input logic [7:0] p);
    int k;
    falls = 0; rx_pat = p; smode = 2; spull = ~p[7];
    wr_reg(8'h08);
    wait_done(k);
    chk(k == 128, "R10 rx timing", k, 128);
    chk(rx_data == p, "R5 rx byte", rx_data, p);
    smode = 0;
  endtask

  task automatic t_ack(input logic v);
    int k;
    cap = '0;
    wr_reg({2'b00, v, 5'h10});
    wait_done(k);
    chk(k == 16, "R10 ack timing", k, 16);
    chk(cap[0] == v, "R8 ack level", cap[0], v);
  endtask

  task automatic t_restart();
    int k, s0;
    s0 = start_seen;
    wr_reg(8'h02);
    wait_done(k);
    chk(k == 24, "R10 restart timing", k, 24);
    chk(start_seen == s0 + 1, "R3 restart event", start_seen, s0 + 1);
    chk(sda_oe && scl_oe, "R3 lines held", {sda_oe, scl_oe}, 3);
  endtask

  task automatic t_busy();
    int k;
    falls = 0; rx_pat = 8'h5A; smode = 2; spull = ~rx_pat[7];
    wr_reg(8'h08);
    repeat (10) @(negedge clk);
    wr_reg(8'h04);
    chk(reg_rdata[4:0] == 5'h08, "R9 bits kept", reg_rdata[4:0], 8);
    wr_buf(8'hFF);
    wait_done(k);
    chk(rx_data == 8'h5A, "R9 rx undisturbed", rx_data, 8'h5A);
    smode = 0; k = 0;
    repeat (60) begin @(negedge clk); if (done_irq) k++; end
    chk(k == 0 && reg_rdata[4:0] == 0, "R9 nothing queued", k, 0);
  endtask

  task automatic t_stop(input int q);
    int k, s0;
    s0 = stop_seen;
    wr_reg(8'h04);
    wait_done(k);
    chk(k == 4 * q, "R10 stop timing", k, 4 * q);
    chk(!sda_oe && !scl_oe, "R4 released", {sda_oe, scl_oe}, 0);
    chk(stop_seen == s0 + 1, "R4 stop event", stop_seen, s0 + 1);
  endtask

  task automatic t_priority();
    int k;
    wr_reg(8'h03);
    chk(reg_rdata[4:0] == 5'h01, "R11 lowest bit", reg_rdata[4:0], 1);
    wait_done(k);
    chk(k == 16, "R11 start runs", k, 16);
  endtask

  task automatic t_fields();
    wr_reg(8'hA0);
    chk(reg_rdata == 8'hE0, "R11 gcen ackdt", reg_rdata, 8'hE0);
    wr_reg(8'h00);
    chk(reg_rdata == 8'h40, "R7 status read-only", reg_rdata, 8'h40);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    t_reset();
    rst_n = 1'b1;
    @(negedge clk);
    t_reset();
    t_start();
    t_tx(8'hA5, 1'b0);
    t_tx(8'h3C, 1'b1);
    t_rx(8'h96);
    t_ack(1'b1);
    t_ack(1'b0);
    t_restart();
    t_busy();
    div_reload = 8'd1;
    t_stop(2);
    div_reload = 8'd3;
    t_priority();
    t_stop(4);
    t_fields();
    summary();
  end
endmodule